// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides its input clock by the total ratio P·SM + SS, where P is a fixed prescaler modulus chosen at build time (32 or 64), SM is the programmed main count and SS is the programmed swallow count. Internally it behaves as a dual-modulus prescaler paired with a main counter and a swallow counter. In every output period the prescaler runs at P+1 for the first SS main-counter steps. It runs at P for the remaining SM−SS steps. The SS extra input cycles taken up this way make the fine part of the ratio.

A synthesizer loop drives the main and swallow inputs with the wanted ratio and takes the one-cycle output pulse as its divided clock. The modulus-select output shows which modulus the prescaler is using at each moment. A new setting is taken only when one output period ends, so a period is never cut short or stretched part-way through. A setting that breaks the rules raises a flag at once. The divider then keeps running on the last good setting.

Top module: `pswal_divider`

## Requirements
- R1: With a valid setting, the interval between two successive output pulses is exactly PRESC·SM + SS input clock cycles. SM is the value on `main_i` and SS is the value on `swallow_i`. Both are plain unsigned binary with bit 0 as the least significant weight.
- R2: Within each output period, `modsel_o` is 1 (prescaler at P+1) for SS·(PRESC+1) input cycles. These are the first cycles of the period. It is 0 (prescaler at P) for the rest of the period. It only rises in the cycle right after an output pulse.
- R3: `pulse_o` is high for exactly one input cycle per output period, in the last cycle of the period.
- R4: A change on `main_i` or `swallow_i` does not alter the output period already running. The new values are taken at the end of that period and first govern the next one.
- R5: `bad_cfg_o` is 1 in the same cycle whenever `main_i` is below 5 or `swallow_i` is not strictly less than `main_i`. Otherwise it is 0.
- R6: While the inputs hold an invalid setting, the divider keeps dividing with the last valid setting it took.
- R7: While `rst_i` is high (synchronous, active high), `pulse_o` is 0 and the counters restart. A valid setting on the inputs during reset governs the first period after reset. That first period is measured from the first clock edge with `rst_i` low.
- R8: PRESC sets the widths. PRESC=64 gives a 6-bit swallow input (0..63) and an 11-bit main input (5..2047). PRESC=32 gives a 5-bit swallow input (0..31) and a 10-bit main input (5..1023). Each build divides by its own PRESC·SM + SS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| main_i | input | log2(PRESC)+5 | Programmed main count SM |
| swallow_i | input | log2(PRESC) | Programmed swallow count SS |
| pulse_o | output | 1 | One-cycle pulse marking the end of each output period |
| modsel_o | output | 1 | Prescaler modulus in use: 1 for P+1, 0 for P |
| bad_cfg_o | output | 1 | Inputs hold a setting that violates the SM/SS rules |

## Verification
The divider is run with SS = 0 (pure P·SM, no swallowed cycles), with SS at its largest legal value SM−1 (prescaler at P+1 for all but one step), and with values in between. This separates errors in the main count from errors in the swallow count, including off-by-one errors at either end. Settings are changed right after a period starts. Two kinds of invalid settings are applied: SM below the minimum, and SS equal to SM. These show whether a setting is taken too early and whether a bad setting can leak into the counters. A second build with the smaller prescaler checks that the ratio follows the parameter.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

    localparam int MIN_MAIN        = 5;
    localparam int MAIN_EXTRA_BITS = 5;
    localparam int SET_SW          = 6;
    localparam int SET_MW          = SET_SW + MAIN_EXTRA_BITS;

    localparam logic [SET_MW-1:0] MIN_MAIN_V = SET_MW'(MIN_MAIN);

    typedef enum logic {
        MOD_BASE = 1'b0,
        MOD_PLUS = 1'b1
    } modulus_e;

    typedef struct packed {
        logic [SET_MW-1:0] main;
        logic [SET_SW-1:0] swal;
    } setting_t;

    localparam setting_t SAFE_SETTING = '{main: MIN_MAIN_V, swal: '0};

    function automatic int swal_bits(input int presc);
        return $clog2(presc);
    endfunction

    function automatic int main_bits(input int presc);
        return $clog2(presc) + MAIN_EXTRA_BITS;
    endfunction

    function automatic logic [SET_MW-1:0] swal_wide(input setting_t s);
        return {{(SET_MW-SET_SW){1'b0}}, s.swal};
    endfunction

    function automatic logic setting_ok(input setting_t s);
        return (s.main >= MIN_MAIN_V) && (swal_wide(s) < s.main);
    endfunction

endpackage

// File: rtl/pswal_setting.sv
module pswal_setting
    import pswal_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  setting_t req_i,
    input  logic     load_i,
    output setting_t act_o,
    output logic     bad_o
);

    setting_t act_q;

    assign bad_o = !setting_ok(req_i);
    assign act_o = act_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q <= bad_o ? SAFE_SETTING : req_i;
        end else if (load_i && !bad_o) begin
            act_q <= req_i;
        end
    end

    // R6: the setting in use always obeys the rules
    p_active_valid_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        setting_ok(act_q));

    // R4: no change of setting except at a period boundary
    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !load_i |=> $stable(act_q));

    // R6: an invalid request at a boundary is not taken
    p_ignore_bad_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (load_i && bad_o) |=> $stable(act_q));

endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
    import pswal_pkg::*;
#(
    parameter int PRESC = 64
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  modulus_e mod_i,
    output logic     tc_o
);

    localparam int CW = $clog2(PRESC) + 1;
    localparam logic [CW-1:0] LAST_BASE = CW'(PRESC - 1);
    localparam logic [CW-1:0] LAST_PLUS = CW'(PRESC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = (mod_i == MOD_PLUS) ? LAST_PLUS : LAST_BASE;
    assign tc_o = (cnt_q == last);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (tc_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count never passes the P+1 terminal value
    p_pre_range_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST_PLUS);

    // R2: a modulus switch to P never strands the count above P-1
    p_base_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (mod_i == MOD_BASE) |-> (cnt_q <= LAST_BASE));

endmodule

// File: rtl/pswal_period_ctl.sv
module pswal_period_ctl
    import pswal_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     tc_i,
    input  setting_t act_i,
    output modulus_e mod_o,
    output logic     end_o
);

    logic [SET_MW-1:0] step_q;
    logic [SET_MW-1:0] last_step;

    assign last_step = act_i.main - 1'b1;
    assign mod_o     = (step_q < swal_wide(act_i)) ? MOD_PLUS : MOD_BASE;
    assign end_o     = tc_i && (step_q == last_step);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            step_q <= '0;
        end else if (tc_i) begin
            step_q <= end_o ? '0 : step_q + 1'b1;
        end
    end

    // R1: the main step count stays inside the programmed SM
    p_step_range_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        step_q < act_i.main);

    // R1: the step count only moves on a prescaler terminal count
    p_step_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !tc_i |=> $stable(step_q));

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
    import pswal_pkg::*;
#(
    parameter int PRESC = 64,
    localparam int SW = swal_bits(PRESC),
    localparam int MW = main_bits(PRESC)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [MW-1:0] main_i,
    input  logic [SW-1:0] swallow_i,
    output logic          pulse_o,
    output logic          modsel_o,
    output logic          bad_cfg_o
);

    setting_t req;
    setting_t act;
    modulus_e mod;
    logic     tc;
    logic     period_end;

    assign req.main = SET_MW'(main_i);
    assign req.swal = SET_SW'(swallow_i);

    pswal_setting u_setting (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (req),
        .load_i (period_end),
        .act_o  (act),
        .bad_o  (bad_cfg_o)
    );

    pswal_prescaler #(.PRESC(PRESC)) u_prescaler (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .mod_i (mod),
        .tc_o  (tc)
    );

    pswal_period_ctl u_period (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tc_i  (tc),
        .act_i (act),
        .mod_o (mod),
        .end_o (period_end)
    );

    assign pulse_o  = period_end;
    assign modsel_o = (mod == MOD_PLUS);

    // R3: the output pulse is one input cycle wide
    p_pulse_width_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    // R2: the P+1 phase can only begin right after a period ends
    p_plus_start_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(modsel_o) |-> $past(pulse_o));

    // R2: the last cycle of a period always runs at modulus P
    p_end_base_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> !modsel_o);

endmodule

// File: tb/test_pswal_divider.sv
module test_pswal_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] main_r = '0;
    logic [5:0]  swal_r = '0;
    logic        pulse, modsel, bad;
    logic        p32_pulse, p32_mod, p32_bad;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int    exp_len[$];
    int    exp_mc[$];
    string exp_tag[$];

    int lv_sm = 0;
    int lv_ss = 0;

    always #10 clk = ~clk;

    pswal_divider #(.PRESC(64)) i_pswal_divider (
        .clk_i     (clk),
        .rst_i     (rst),
        .main_i    (main_r),
        .swallow_i (swal_r),
        .pulse_o   (pulse),
        .modsel_o  (modsel),
        .bad_cfg_o (bad)
    );

    pswal_divider #(.PRESC(32)) i_pswal_divider_p32 (
        .clk_i     (clk),
        .rst_i     (rst),
        .main_i    (10'd5),
        .swallow_i (5'd3),
        .pulse_o   (p32_pulse),
        .modsel_o  (p32_mod),
        .bad_cfg_o (p32_bad)
    );

    task automatic check(input bit ok, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic set_cfg(input int sm, input int ss);
        main_r = 11'(sm);
        swal_r = 6'(ss);
    endtask

    task automatic push_exp(input int sm, input int ss, input string tag);
        exp_len.push_back(64 * sm + ss);
        exp_mc.push_back(ss * 65);
        exp_tag.push_back(tag);
    endtask

    task automatic next_period();
        do @(negedge clk); while (!pulse);
        @(posedge clk);
        #2;
    endtask

    // Called right after a period has started; the running period keeps the old setting.
    task automatic step(input int sm, input int ss, input int count, input string tag);
        bit valid;
        set_cfg(sm, ss);
        #1;
        valid = (sm >= 5) && (ss < sm);
        check(bad == !valid, "R5 bad_cfg_o", int'(bad), int'(!valid));
        if (valid) begin
            lv_sm = sm;
            lv_ss = ss;
        end
        for (int i = 0; i < count; i++) begin
            push_exp(lv_sm, lv_ss, tag);
            next_period();
        end
    endtask

    // Scoreboard monitor
    int  since = 0;
    int  mcc   = 0;
    bit  prev  = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            since = 0;
            mcc   = 0;
            prev  = 1'b0;
        end else begin
            since++;
            if (modsel) mcc++;
            if (pulse) begin
                check(!prev, "R3 pulse wider than one cycle", 1, 0);
                if (exp_len.size() == 0) begin
                    check(1'b0, "R1 unexpected pulse", since, 0);
                end else begin
                    int    el;
                    int    em;
                    string tg;
                    el = exp_len.pop_front();
                    em = exp_mc.pop_front();
                    tg = exp_tag.pop_front();
                    check(since == el, {tg, "/R1 period length"}, since, el);
                    check(mcc == em, {tg, "/R2 cycles at P+1"}, mcc, em);
                end
                since = 0;
                mcc   = 0;
            end
            prev = pulse;
        end
    end

    // Second build, PRESC=32, SM=5, SS=3
    int  s32 = 0;
    int  m32 = 0;
    bit  seen32 = 1'b0;
    always @(negedge clk) begin
        if (rst) begin
            s32 = 0;
            m32 = 0;
        end else if (!seen32) begin
            s32++;
            if (p32_mod) m32++;
            if (p32_pulse) begin
                seen32 = 1'b1;
                check(s32 == 163, "R8 P=32 period length", s32, 163);
                check(m32 == 99, "R8 P=32 cycles at P+1", m32, 99);
            end
        end
    end

    initial begin
        set_cfg(5, 0);
        lv_sm = 5;
        lv_ss = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pulse == 1'b0, "R7 pulse in reset", int'(pulse), 0);
        check(modsel == 1'b0, "R7 modsel in reset", int'(modsel), 0);
        check(bad == 1'b0, "R7 bad_cfg in reset", int'(bad), 0);
        @(posedge clk);
        #2;
        rst = 1'b0;
        push_exp(5, 0, "R7");

        step(5, 4, 2, "R4");
        step(20, 19, 1, "R4");
        step(7, 3, 2, "R1");
        step(4, 0, 1, "R6");
        step(6, 6, 1, "R6");
        step(9, 0, 1, "R4");
        next_period();

        check(exp_len.size() == 0, "R1 leftover expected periods", exp_len.size(), 0);
        check(seen32, "R8 P=32 pulse seen", int'(seen32), 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule